// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-up Sequencer

This block trains a root-port link in two steps. On a start pulse it caps the link at first-generation speed in the core's link capability register and turns on the training state machine. It then waits for link up. Once the link is up, it raises the cap to second generation and requests a directed speed change. It polls the self-clearing change bit until it drops, waits for link up again, and finally reads the negotiated speed from the link status register. All register traffic goes through a single-outstanding request/acknowledge port toward the controller core. Every wait is a bounded series of polls, and the spacing between polls is set in clock cycles by an input.

A system controller raises `start_i` after reset, or again after a finished attempt. It then watches `done_o` and `fail_o`. Only one of the two is ever high, and it stays high until the next accepted start.

Top module: `lbs_link_seq`

## Requirements
- R1: Before training is enabled, the block reads the link capability register (address 0x07C) and writes the same word back with bits 3:0 replaced by speed code 1 (first generation). All other bits are kept.
- R2: `ltssm_en_o` goes low when a start is accepted. It stays low until the write of R1 has been acknowledged, and goes high in the cycle after that acknowledge.
- R3: The first link wait checks `link_up_i` at most MAX_POLLS (200) times. After each miss it idles for `poll_delay_i` cycles before the next check. If every check misses, the block fails and issues no further register writes.
- R4: After the first link up, the block rewrites the capability register with bits 3:0 set to code 2, keeping all other bits. It then reads the speed control register (address 0x80C) and writes it back with bit 17 set and all other bits kept.
- R5: After the write of R4, the block reads address 0x80C until bit 17 reads zero. It makes at most 200 such reads, with `poll_delay_i` idle cycles between them. If bit 17 is still one on the 200th read, the block fails.
- R6: Once bit 17 reads zero, the link is waited for a second time under the rules of R3. If every check misses, the block fails without reading the status register.
- R7: After the second link up, the block reads the link status register (address 0x080), drives bits 19:16 of that word on `link_speed_o`, and raises `done_o`. `link_speed_o` reads zero from each accepted start until then.
- R8: `done_o` and `fail_o` are never high together. Once set, either one stays high until the next start, and an accepted start clears both in the following cycle.
- R9: `start_i` is ignored while a sequence is in progress. It is only accepted when the block is idle, done or failed.
- R10: A register request holds `reg_req_o`, address, write enable and write data steady until `reg_ack_i`. Only one request is outstanding at a time: the request drops in the cycle after its acknowledge. Read data is taken from `reg_rdata_i` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up attempt |
| poll_delay_i | input | DLY_W (16) | Idle cycles between polls |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W (12) | Register byte address |
| reg_wdata_o | output | DATA_W (32) | Write data |
| reg_ack_i | input | 1 | Access complete; read data valid |
| reg_rdata_i | input | DATA_W (32) | Read data |
| ltssm_en_o | output | 1 | Enable for the link training state machine |
| link_up_i | input | 1 | Link-up status from the core |
| done_o | output | 1 | Sequence finished successfully |
| fail_o | output | 1 | Sequence aborted |
| link_speed_o | output | 4 | Negotiated speed code |

## Verification
The bench targets the poll limits at their exact edges. With the change bit busy for 199 reads the sequence must still pass; with 200 it must fail after exactly 200 reads. A counter off by one in either direction flips one of these two outcomes. A link that never comes up must cause a failure only after at least 199 full delay periods, which exposes a design that ignores the delay or stops polling early. Read-modify-write values are checked against preset neighbour bits: a design that writes constants, or reads the wrong word, loses those bits. Training must still be disabled at the first speed-cap write, so enabling the state machine too early is caught. A start pulse in the middle of a run must leave the register traffic unchanged, and done and fail must stay set until the next start.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CAP1_RD, ST_CAP1_WR, ST_LINK1, ST_CAP2_RD, ST_CAP2_WR,
    ST_SC_RD, ST_SC_WR, ST_SC_POLL, ST_LINK2, ST_STAT_RD, ST_DONE, ST_FAIL
  } seq_state_e;

  localparam logic [3:0] SPEED_GEN1 = 4'd1;
  localparam logic [3:0] SPEED_GEN2 = 4'd2;
endpackage

// File: rtl/lbs_reg_master.sv
module lbs_reg_master #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (cmd_valid_i) begin
      req_q   <= 1'b1;
      we_o    <= cmd_we_i;
      addr_o  <= cmd_addr_i;
      wdata_o <= cmd_wdata_i;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign req_o       = req_q;
  assign rsp_valid_o = req_q && ack_i;
  assign rsp_data_o  = rdata_i;
endmodule

// File: rtl/lbs_poll_timer.sv
module lbs_poll_timer #(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned MAX_POLLS = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             miss_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             busy_o,
  output logic             last_o
);
  localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dly_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      dly_q <= '0;
    end else if (miss_i) begin
      cnt_q <= cnt_q + 1'b1;
      dly_q <= delay_i;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  assign busy_o = (dly_q != '0);
  // the check in progress is the final one allowed
  assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/lbs_link_seq.sv
module lbs_link_seq #(
  parameter int unsigned          ADDR_W      = 12,
  parameter int unsigned          DATA_W      = 32,
  parameter int unsigned          DLY_W       = 16,
  parameter int unsigned          MAX_POLLS   = 200,
  parameter logic [ADDR_W-1:0]    CAP_ADDR    = 'h07C,
  parameter logic [ADDR_W-1:0]    STAT_ADDR   = 'h080,
  parameter logic [ADDR_W-1:0]    SPDCTL_ADDR = 'h80C,
  parameter int unsigned          CHG_BIT     = 17,
  parameter int unsigned          SPD_LSB     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DLY_W-1:0]  poll_delay_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              ltssm_en_o,
  input  logic              link_up_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [3:0]        link_speed_o
);
  import lbs_pkg::*;

  localparam logic [DATA_W-1:0] CHG_MASK = DATA_W'(1) << CHG_BIT;

  seq_state_e        state_q, state_d;
  logic              issued_q;
  logic [DATA_W-1:0] shadow_q;
  logic              ltssm_q;
  logic [3:0]        speed_q;

  logic              cmd_valid, cmd_we;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              poll_clr, poll_miss, tmr_busy, tmr_last;
  logic              accept;

  lbs_reg_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .req_o       (reg_req_o),
    .we_o        (reg_we_o),
    .addr_o      (reg_addr_o),
    .wdata_o     (reg_wdata_o),
    .ack_i       (reg_ack_i),
    .rdata_i     (reg_rdata_i),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  lbs_poll_timer #(.DLY_W(DLY_W), .MAX_POLLS(MAX_POLLS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (poll_clr),
    .miss_i  (poll_miss),
    .delay_i (poll_delay_i),
    .busy_o  (tmr_busy),
    .last_o  (tmr_last)
  );

  always_comb begin
    state_d   = state_q;
    cmd_valid = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = CAP_ADDR;
    cmd_wdata = '0;
    poll_clr  = 1'b0;
    poll_miss = 1'b0;
    accept    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          accept  = 1'b1;
          state_d = ST_CAP1_RD;
        end
      end
      ST_CAP1_RD, ST_CAP2_RD: begin
        cmd_valid = !issued_q;
        if (rsp_valid) state_d = (state_q == ST_CAP1_RD) ? ST_CAP1_WR : ST_CAP2_WR;
      end
      ST_CAP1_WR: begin
        cmd_valid = !issued_q;
        cmd_we    = 1'b1;
        cmd_wdata = {shadow_q[DATA_W-1:4], SPEED_GEN1};
        if (rsp_valid) begin
          poll_clr = 1'b1;
          state_d  = ST_LINK1;
        end
      end
      ST_CAP2_WR: begin
        cmd_valid = !issued_q;
        cmd_we    = 1'b1;
        cmd_wdata = {shadow_q[DATA_W-1:4], SPEED_GEN2};
        if (rsp_valid) state_d = ST_SC_RD;
      end
      ST_LINK1, ST_LINK2: begin
        if (!tmr_busy) begin
          if (link_up_i)     state_d = (state_q == ST_LINK1) ? ST_CAP2_RD : ST_STAT_RD;
          else if (tmr_last) state_d = ST_FAIL;
          else               poll_miss = 1'b1;
        end
      end
      ST_SC_RD: begin
        cmd_valid = !issued_q;
        cmd_addr  = SPDCTL_ADDR;
        if (rsp_valid) state_d = ST_SC_WR;
      end
      ST_SC_WR: begin
        cmd_valid = !issued_q;
        cmd_we    = 1'b1;
        cmd_addr  = SPDCTL_ADDR;
        cmd_wdata = shadow_q | CHG_MASK;
        if (rsp_valid) begin
          poll_clr = 1'b1;
          state_d  = ST_SC_POLL;
        end
      end
      ST_SC_POLL: begin
        cmd_valid = !issued_q && !tmr_busy;
        cmd_addr  = SPDCTL_ADDR;
        if (rsp_valid) begin
          if (!rsp_data[CHG_BIT]) begin
            poll_clr = 1'b1;
            state_d  = ST_LINK2;
          end else if (tmr_last) begin
            state_d = ST_FAIL;
          end else begin
            poll_miss = 1'b1;
          end
        end
      end
      ST_STAT_RD: begin
        cmd_valid = !issued_q;
        cmd_addr  = STAT_ADDR;
        if (rsp_valid) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      shadow_q <= '0;
      ltssm_q  <= 1'b0;
      speed_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_valid)      issued_q <= 1'b1;
      else if (rsp_valid) issued_q <= 1'b0;
      if (rsp_valid && !cmd_we) shadow_q <= rsp_data;
      if (accept) begin
        ltssm_q <= 1'b0;
        speed_q <= '0;
      end
      if (state_q == ST_CAP1_WR && rsp_valid) ltssm_q <= 1'b1;
      if (state_q == ST_STAT_RD && rsp_valid) speed_q <= rsp_data[SPD_LSB +: 4];
    end
  end

  assign ltssm_en_o   = ltssm_q;
  assign done_o       = (state_q == ST_DONE);
  assign fail_o       = (state_q == ST_FAIL);
  assign link_speed_o = speed_q;
endmodule

// File: rtl/lbs_link_seq_chk.sv
module lbs_link_seq_chk #(
  parameter int unsigned       ADDR_W   = 12,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CAP_ADDR = 'h07C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              reg_req_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_ack_i,
  input logic              ltssm_en_o,
  input logic              done_o,
  input logic              fail_o
);
  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_fail_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) &&
    $stable(reg_we_o) && $stable(reg_wdata_o));

  assert_single_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i |=> !reg_req_o);

  assert_ltssm_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ltssm_en_o) |-> $past(start_i));

  assert_ltssm_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ltssm_en_o) |-> $past(reg_ack_i && reg_req_o && reg_we_o &&
    reg_addr_o == CAP_ADDR && reg_wdata_o[3:0] == 4'd1));

  assert_done_trained_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ltssm_en_o);
endmodule

bind lbs_link_seq lbs_link_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_ADDR(CAP_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .reg_req_o   (reg_req_o),
  .reg_we_o    (reg_we_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .reg_ack_i   (reg_ack_i),
  .ltssm_en_o  (ltssm_en_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/tb_lbs_link_seq.sv
`timescale 1ns/1ps
module tb_lbs_link_seq;
  localparam logic [31:0] CAP_INIT = 32'h1234_5673;
  localparam logic [31:0] SC_INIT  = 32'h0001_00A5;
  localparam logic [31:0] CHG      = 32'h0002_0000;
  localparam int NEVER = -1;

  typedef struct packed {
    int l1; int k; int l2; int spd; int dly; int ok;
  } vec_t;

  localparam vec_t TABLE [6] = '{
    '{l1: 5,     k: 3,   l2: 4,     spd: 2, dly: 3, ok: 1},
    '{l1: 0,     k: 0,   l2: 0,     spd: 1, dly: 0, ok: 1},
    '{l1: NEVER, k: 0,   l2: 0,     spd: 2, dly: 3, ok: 0},
    '{l1: 2,     k: 199, l2: 1,     spd: 2, dly: 1, ok: 1},
    '{l1: 2,     k: 200, l2: 1,     spd: 2, dly: 1, ok: 0},
    '{l1: 3,     k: 2,   l2: NEVER, spd: 2, dly: 2, ok: 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] poll_delay = '0;
  logic        reg_req, reg_we, reg_ack = 1'b0;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata = '0;
  logic        ltssm_en, link_up = 1'b0;
  logic        done, fail;
  logic [3:0]  link_speed;

  always #2.5 clk = ~clk;

  lbs_link_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .poll_delay_i(poll_delay),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_ack_i(reg_ack), .reg_rdata_i(reg_rdata),
    .ltssm_en_o(ltssm_en), .link_up_i(link_up), .done_o(done), .fail_o(fail),
    .link_speed_o(link_speed)
  );

  int tests = 0, fails = 0;
  // core model state
  logic [31:0] cap_reg, sc_reg, stat_reg;
  logic [31:0] cap_wr_val [2];
  logic [31:0] sc_wr_val;
  int cap_wr_cnt, sc_wr_cnt, sc_reads, stat_rd_cnt, lat, phase, lcnt;
  int cfg_l1, cfg_k, cfg_l2;
  logic sc_pending, ltssm_at_first;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    int lim;
    if (reg_ack) reg_ack = 1'b0;
    else if (reg_req) begin
      if (lat >= 1) begin
        lat = 0;
        reg_ack = 1'b1;
        reg_rdata = 32'hDEAD_BEEF;
        if (reg_we) begin
          if (reg_addr == 12'h07C) begin
            if (cap_wr_cnt == 0) ltssm_at_first = ltssm_en;
            if (cap_wr_cnt < 2) cap_wr_val[cap_wr_cnt] = reg_wdata;
            cap_wr_cnt++;
            cap_reg = reg_wdata;
          end else if (reg_addr == 12'h80C) begin
            sc_wr_val = reg_wdata;
            sc_wr_cnt++;
            sc_reg = reg_wdata & ~CHG;
            if (reg_wdata[17]) begin
              sc_pending = 1'b1; sc_reads = 0; phase = 2; lcnt = 0; link_up = 1'b0;
            end
          end
        end else begin
          if (reg_addr == 12'h07C) reg_rdata = cap_reg;
          else if (reg_addr == 12'h080) begin reg_rdata = stat_reg; stat_rd_cnt++; end
          else if (reg_addr == 12'h80C) begin
            reg_rdata = sc_reg;
            if (sc_pending) begin
              if (sc_reads < cfg_k) reg_rdata = sc_reg | CHG;
              else sc_pending = 1'b0;
              sc_reads++;
            end
          end
        end
      end else lat++;
    end
    if (!ltssm_en) begin
      phase = 1; lcnt = 0; link_up = 1'b0;
    end else begin
      lim = (phase == 1) ? cfg_l1 : cfg_l2;
      link_up = (lim >= 0) && (lcnt >= lim);
      lcnt++;
    end
  endtask

  initial begin
    lat = 0; phase = 1; lcnt = 0;
    forever begin
      @(negedge clk);
      model_step();
    end
  end

  int elapsed;

  task automatic run(int l1, int k, int l2, int spd, int dly, bit mid_start);
    bit injected = 0;
    cap_reg = CAP_INIT; sc_reg = SC_INIT;
    stat_reg = {12'hA5C, 4'(spd), 16'h3C3C};
    cap_wr_cnt = 0; sc_wr_cnt = 0; sc_reads = 0; stat_rd_cnt = 0;
    cap_wr_val[0] = '0; cap_wr_val[1] = '0; sc_wr_val = '0;
    sc_pending = 1'b0; ltssm_at_first = 1'b1;
    cfg_l1 = l1; cfg_k = k; cfg_l2 = l2;
    poll_delay = 16'(dly);
    elapsed = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 start clears done/fail", {30'd0, done, fail}, 32'd0);
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (ltssm_en) elapsed++;
      if (done || fail) break;
      if (mid_start && ltssm_en && !injected) begin
        start = 1'b1; injected = 1;
      end
    end
    start = 1'b0;
    if (!(done || fail)) chk("R8 sequence ended", 32'd0, 32'd1);
  endtask

  initial begin
    #950000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset done", {31'd0, done}, 32'd0);
    chk("R8 reset fail", {31'd0, fail}, 32'd0);
    chk("R2 reset ltssm", {31'd0, ltssm_en}, 32'd0);
    chk("R10 reset req", {31'd0, reg_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run(TABLE[v].l1, TABLE[v].k, TABLE[v].l2, TABLE[v].spd, TABLE[v].dly, 1'b0);
      chk("R8 done", {31'd0, done}, 32'(TABLE[v].ok));
      chk("R8 fail", {31'd0, fail}, 32'(!TABLE[v].ok));
      chk("R1 gen1 rmw", cap_wr_val[0], {CAP_INIT[31:4], 4'd1});
      chk("R2 ltssm low at gen1 write", {31'd0, ltssm_at_first}, 32'd0);
      if (TABLE[v].ok) begin
        chk("R7 speed", {28'd0, link_speed}, 32'(TABLE[v].spd));
        chk("R4 gen2 rmw", cap_wr_val[1], {CAP_INIT[31:4], 4'd2});
        chk("R4 change request", sc_wr_val, SC_INIT | CHG);
        chk("R5 poll reads", 32'(sc_reads), 32'(TABLE[v].k + 1));
        chk("R10 read data path", cap_reg, {CAP_INIT[31:4], 4'd2});
      end
      if (TABLE[v].l1 == NEVER) begin
        chk("R3 no writes after fail cap", 32'(cap_wr_cnt), 32'd1);
        chk("R3 no writes after fail sc", 32'(sc_wr_cnt), 32'd0);
      end
      if (TABLE[v].k >= 200) chk("R5 read limit", 32'(sc_reads), 32'd200);
      if (TABLE[v].l2 == NEVER) begin
        chk("R6 second wait passed change", 32'(sc_wr_cnt), 32'd1);
        chk("R6 no status read", 32'(stat_rd_cnt), 32'd0);
        chk("R7 speed stays zero", {28'd0, link_speed}, 32'd0);
      end
    end

    // R8 hold until next start
    repeat (40) @(negedge clk);
    chk("R8 fail held", {31'd0, fail}, 32'd1);

    // R3 poll spacing: never-up link with delay 20
    run(NEVER, 0, 0, 2, 20, 1'b0);
    chk("R3 fail", {31'd0, fail}, 32'd1);
    chk("R3 min wait", 32'(elapsed >= 199 * 20), 32'd1);
    chk("R3 max wait", 32'(elapsed <= 200 * 21 + 20), 32'd1);

    // R3 late link within window
    run(150 * 21, 1, 1, 2, 20, 1'b0);
    chk("R3 late link done", {31'd0, done}, 32'd1);

    // R9 start mid-run ignored
    run(10, 2, 3, 1, 2, 1'b1);
    chk("R9 done", {31'd0, done}, 32'd1);
    chk("R9 cap writes", 32'(cap_wr_cnt), 32'd2);
    chk("R9 speed", {28'd0, link_speed}, 32'd1);
    repeat (30) @(negedge clk);
    chk("R8 done held", {31'd0, done}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule